// File: doc/BRIEF.md
# Squared-Envelope Pulse Detector

This streaming block decides, sample by sample, whether a pulse is present in a noisy input whose carrier frequency is not known in advance. Each accepted signed sample is multiplied by itself, so the carrier sign drops out and only energy is left. The result is then scaled by four. A low-pass FIR and a keep-one-in-D downsampler decimate the scaled energy. A second, narrower low-pass FIR with 21 taps smooths the decimated stream again. The smoothed envelope is compared against a fixed level of 2.5, and a one-bit decision comes out with its own valid strobe.

The input is a signed fixed-point sample with a programmable number of fraction bits. Squaring doubles that fraction count, and both filters shift their sums right by the coefficient fraction width. The envelope therefore carries twice the input fraction bits, and the threshold constant is derived from that scale. The filter coefficients, the decimation factor and every width are elaboration-time parameters. Each stage acts only on its own input strobe, so gaps in the input stall all filter state.

Top module: `pulse_env_detector`

## Requirements
- R1: For every accepted sample, the squaring stage yields a value that is never negative. A sample and its negation give identical results downstream.
- R2: The squared value is multiplied by exactly 4 (a left shift by two) at full precision. For a constant input x, with both coefficient sets summing to 1.0, the settled envelope equals 4·x² in the envelope scale.
- R3: The first FIR runs on every accepted sample. The downsampler forwards one first-filter output out of every DECIM, beginning with the DECIM-th output after reset. No two consecutive cycles carry a decimated output when DECIM > 1.
- R4: The second filter is a 21-tap FIR on the decimated stream. Each filter output is floor(Σ c_k·h_k / 2^COEF_FRAC), where h_0 is the newest input and the coefficients are signed COEF_W-bit values.
- R5: det_pulse is 1 exactly when the second-filter output is strictly greater than 2.5 in the envelope scale (5·2^(2·IN_FRAC−1) counts), and 0 otherwise, including on equality.
- R6: det_valid is registered and rises exactly four clock cycles after the rising edge that captures the input sample completing a decimation group. det_pulse is valid in the same cycle.
- R7: While in_valid is low, in_sample is ignored and no filter state, decimation count or output strobe changes.
- R8: A synchronous reset clears both delay lines, the decimation count and the output strobe. Behaviour after release matches a fresh start.
- R9: No stage overflows: a sustained full-scale negative input gives the exact mathematical envelope and a detection.
- R10: A noise-only stretch well below the threshold, once the filter tails from an earlier pulse have flushed, produces no detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | IN_W | Signed input sample with IN_FRAC fraction bits |
| det_valid | output | 1 | Decision strobe, one per decimated output |
| det_pulse | output | 1 | 1 when the smoothed envelope exceeds 2.5 |

## Verification
The bench builds the detector with IN_FRAC = 9, a six-tap first filter, DECIM = 3 and a 21-tap second filter that has negative outer taps. Both coefficient sets sum to exactly 1.0. With a three-phase decimation count, a count that is off by one shows up as a misplaced decision. The negative taps drive the envelope below zero after an impulse, which exercises signed truncation. Because the coefficients sum to unity, a constant input settles to exactly 4·x². Inputs of 404 and 405 then fall just below and just above the 2.5 level, the closest the threshold can be approached, since equality cannot be reached with a constant input.

// File: rtl/pulse_env_pkg.sv
package pulse_env_pkg;

   localparam int COEF_MAX_BITS = 64 * 32;

   // Triangular low-pass shape: tap k weighs min(k+1, taps-k) * scale.
   function automatic logic [COEF_MAX_BITS-1:0] tri_coefs(int taps, int scale, int cw);
      logic [COEF_MAX_BITS-1:0] v;
      logic [COEF_MAX_BITS-1:0] one;
      v = '0;
      for (int k = 0; k < taps; k++) begin
         int w;
         w   = (k + 1 < taps - k) ? (k + 1) : (taps - k);
         one = COEF_MAX_BITS'(w * scale) & ((COEF_MAX_BITS'(1) << cw) - 1);
         v   = v | (one << (k * cw));
      end
      return v;
   endfunction

endpackage

// File: rtl/env_square.sv
module env_square #(
   parameter int IN_W    = 12,
   parameter int GAIN_SH = 2,
   parameter int SQ_W    = 2 * IN_W + GAIN_SH
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   din_valid,
   input  logic signed [IN_W-1:0] din,
   output logic                   dout_valid,
   output logic signed [SQ_W-1:0] dout
);

   logic signed [2*IN_W-1:0] prod;

   assign prod = din * din;

   always_ff @(posedge clk) begin
      if (rst) begin
         dout_valid <= 1'b0;
         dout       <= '0;
      end else begin
         dout_valid <= din_valid;
         if (din_valid) dout <= SQ_W'(prod) <<< GAIN_SH;
      end
   end

endmodule

// File: rtl/env_fir.sv
module env_fir #(
   parameter int DATA_W    = 26,
   parameter int COEF_W    = 16,
   parameter int TAPS      = 8,
   parameter int SHIFT     = 15,
   parameter int OUT_W     = 30,
   parameter bit SYMMETRIC = 1'b1,
   parameter logic [TAPS*COEF_W-1:0] COEFS = '0
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     din_valid,
   input  logic signed [DATA_W-1:0] din,
   output logic                     dout_valid,
   output logic signed [OUT_W-1:0]  dout
);

   localparam int ACC_W = DATA_W + COEF_W + $clog2(TAPS) + 1;

   if (TAPS < 2) begin : g_bad_taps
      $error("env_fir: TAPS must be at least 2");
   end
   if (OUT_W != ACC_W - SHIFT) begin : g_bad_out
      $error("env_fir: OUT_W must equal accumulator width minus SHIFT");
   end

   function automatic logic signed [COEF_W-1:0] coef(int k);
      return COEFS[k*COEF_W +: COEF_W];
   endfunction

   logic signed [DATA_W-1:0] dl  [TAPS-1];
   logic signed [DATA_W-1:0] tap [TAPS];
   logic signed [ACC_W-1:0]  acc;

   always_comb begin
      tap[0] = din;
      for (int k = 1; k < TAPS; k++) tap[k] = dl[k-1];
   end

   if (SYMMETRIC) begin : g_fold
      always_comb begin
         acc = '0;
         for (int k = 0; k < TAPS / 2; k++)
            acc = acc + ACC_W'(coef(k)) * (ACC_W'(tap[k]) + ACC_W'(tap[TAPS-1-k]));
         if (TAPS % 2 == 1)
            acc = acc + ACC_W'(coef(TAPS / 2)) * ACC_W'(tap[TAPS / 2]);
      end
   end else begin : g_direct
      always_comb begin
         acc = '0;
         for (int k = 0; k < TAPS; k++)
            acc = acc + ACC_W'(coef(k)) * ACC_W'(tap[k]);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < TAPS - 1; k++) dl[k] <= '0;
         dout_valid <= 1'b0;
         dout       <= '0;
      end else begin
         dout_valid <= din_valid;
         if (din_valid) begin
            for (int k = 0; k < TAPS - 1; k++) dl[k] <= tap[k];
            dout <= OUT_W'(acc >>> SHIFT);
         end
      end
   end

endmodule

// File: rtl/env_downsample.sv
module env_downsample #(
   parameter int DATA_W = 30,
   parameter int DECIM  = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     din_valid,
   input  logic signed [DATA_W-1:0] din,
   output logic                     dout_valid,
   output logic signed [DATA_W-1:0] dout
);

   if (DECIM < 1) begin : g_bad_decim
      $error("env_downsample: DECIM must be at least 1");
   end

   if (DECIM == 1) begin : g_pass
      always_ff @(posedge clk) begin
         if (rst) begin
            dout_valid <= 1'b0;
            dout       <= '0;
         end else begin
            dout_valid <= din_valid;
            if (din_valid) dout <= din;
         end
      end
   end else begin : g_count
      localparam int CW = $clog2(DECIM);
      logic [CW-1:0] phase;
      always_ff @(posedge clk) begin
         if (rst) begin
            phase      <= '0;
            dout_valid <= 1'b0;
            dout       <= '0;
         end else begin
            dout_valid <= 1'b0;
            if (din_valid) begin
               if (phase == CW'(DECIM - 1)) begin
                  phase      <= '0;
                  dout_valid <= 1'b1;
                  dout       <= din;
               end else begin
                  phase <= phase + 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/pulse_env_detector.sv
module pulse_env_detector #(
   parameter int IN_W      = 12,
   parameter int IN_FRAC   = 9,
   parameter int GAIN_SH   = 2,
   parameter int COEF_W    = 16,
   parameter int COEF_FRAC = 15,
   parameter int TAPS1     = 8,
   parameter int DECIM     = 4,
   parameter int TAPS2     = 21,
   parameter bit SYMMETRIC = 1'b1,
   parameter logic [TAPS1*COEF_W-1:0] COEF1 =
      (TAPS1*COEF_W)'(pulse_env_pkg::tri_coefs(8, 1638, 16)),
   parameter logic [TAPS2*COEF_W-1:0] COEF2 =
      (TAPS2*COEF_W)'(pulse_env_pkg::tri_coefs(21, 270, 16))
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_valid,
   input  logic signed [IN_W-1:0] in_sample,
   output logic                   det_valid,
   output logic                   det_pulse
);

   localparam int SQ_W     = 2 * IN_W + GAIN_SH;
   localparam int W1       = SQ_W + COEF_W + $clog2(TAPS1) + 1 - COEF_FRAC;
   localparam int W2       = W1 + COEF_W + $clog2(TAPS2) + 1 - COEF_FRAC;
   localparam int ENV_FRAC = 2 * IN_FRAC;
   localparam logic signed [W2-1:0] THRESH = W2'(5) << (ENV_FRAC - 1);

   if (IN_FRAC < 1 || IN_FRAC >= IN_W) begin : g_bad_frac
      $error("pulse_env_detector: IN_FRAC out of range");
   end
   if (W2 < ENV_FRAC + 4) begin : g_bad_env
      $error("pulse_env_detector: envelope too narrow for the threshold");
   end

   logic                   sq_valid;
   logic signed [SQ_W-1:0] sq_data;
   logic                   f1_valid;
   logic signed [W1-1:0]   f1_data;
   logic                   dec_valid;
   logic signed [W1-1:0]   dec_data;
   logic                   f2_valid;
   logic signed [W2-1:0]   f2_data;

   env_square #(.IN_W(IN_W), .GAIN_SH(GAIN_SH), .SQ_W(SQ_W)) u_square (
      .clk(clk), .rst(rst), .din_valid(in_valid), .din(in_sample),
      .dout_valid(sq_valid), .dout(sq_data));

   env_fir #(.DATA_W(SQ_W), .COEF_W(COEF_W), .TAPS(TAPS1), .SHIFT(COEF_FRAC),
             .OUT_W(W1), .SYMMETRIC(SYMMETRIC), .COEFS(COEF1)) u_fir_decim (
      .clk(clk), .rst(rst), .din_valid(sq_valid), .din(sq_data),
      .dout_valid(f1_valid), .dout(f1_data));

   env_downsample #(.DATA_W(W1), .DECIM(DECIM)) u_down (
      .clk(clk), .rst(rst), .din_valid(f1_valid), .din(f1_data),
      .dout_valid(dec_valid), .dout(dec_data));

   env_fir #(.DATA_W(W1), .COEF_W(COEF_W), .TAPS(TAPS2), .SHIFT(COEF_FRAC),
             .OUT_W(W2), .SYMMETRIC(SYMMETRIC), .COEFS(COEF2)) u_fir_smooth (
      .clk(clk), .rst(rst), .din_valid(dec_valid), .din(dec_data),
      .dout_valid(f2_valid), .dout(f2_data));

   always_ff @(posedge clk) begin
      if (rst) begin
         det_valid <= 1'b0;
         det_pulse <= 1'b0;
      end else begin
         det_valid <= f2_valid;
         if (f2_valid) det_pulse <= f2_data > THRESH;
      end
   end

endmodule

// File: rtl/pulse_env_checker.sv
module pulse_env_checker #(
   parameter int IN_W    = 12,
   parameter int GAIN_SH = 2,
   parameter int SQ_W    = 26,
   parameter int W2      = 36,
   parameter int DECIM   = 4,
   parameter logic signed [W2-1:0] THRESH = '0
) (
   input logic                   clk,
   input logic                   rst,
   input logic                   in_valid,
   input logic signed [IN_W-1:0] in_sample,
   input logic                   sq_valid,
   input logic signed [SQ_W-1:0] sq_data,
   input logic                   f1_valid,
   input logic                   dec_valid,
   input logic                   f2_valid,
   input logic signed [W2-1:0]   f2_data,
   input logic                   det_valid,
   input logic                   det_pulse
);

   p_sq_nonneg_r1: assert property (@(posedge clk) disable iff (rst)
      sq_valid |-> !sq_data[SQ_W-1]);

   p_gain_r2: assert property (@(posedge clk) disable iff (rst)
      sq_valid |-> sq_data == ((SQ_W'($past(in_sample)) * SQ_W'($past(in_sample))) <<< GAIN_SH));

   p_dec_src_r3: assert property (@(posedge clk) disable iff (rst)
      dec_valid |-> $past(f1_valid));

   p_dec_gap_r3: assert property (@(posedge clk) disable iff (rst)
      (DECIM > 1 && dec_valid) |=> !dec_valid);

   p_thresh_r5: assert property (@(posedge clk) disable iff (rst)
      det_valid |-> det_pulse == ($past(f2_data) > THRESH));

   p_lat_out_r6: assert property (@(posedge clk) disable iff (rst)
      det_valid |-> $past(f2_valid));

   p_lat_smooth_r6: assert property (@(posedge clk) disable iff (rst)
      f2_valid |-> $past(dec_valid));

   p_stall_r7: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !sq_valid);

   p_reset_r8: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!det_valid && !sq_valid));

endmodule

bind pulse_env_detector pulse_env_checker #(
   .IN_W(IN_W), .GAIN_SH(GAIN_SH), .SQ_W(SQ_W), .W2(W2), .DECIM(DECIM), .THRESH(THRESH)
) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
   .sq_valid(sq_valid), .sq_data(sq_data), .f1_valid(f1_valid),
   .dec_valid(dec_valid), .f2_valid(f2_valid), .f2_data(f2_data),
   .det_valid(det_valid), .det_pulse(det_pulse)
);

// File: tb/pulse_env_detector_bench.sv
module pulse_env_detector_bench;

   localparam int IN_W  = 12;
   localparam int FRAC  = 9;
   localparam int T1    = 6;
   localparam int T2    = 21;
   localparam int D     = 3;
   localparam int CW    = 16;
   localparam longint THR = longint'(5) <<< (2 * FRAC - 1);

   function automatic longint bc1(int k);
      case (k)
         0, 5:    return 2000;
         1, 4:    return 6000;
         default: return 8384;
      endcase
   endfunction

   function automatic longint bc2(int k);
      int d;
      d = (k > 10) ? k - 10 : 10 - k;
      return (d == 0) ? 7768 : 2900 - 300 * d;
   endfunction

   function automatic logic [T1*CW-1:0] pk1();
      logic [T1*CW-1:0] v;
      for (int k = 0; k < T1; k++) v[k*CW +: CW] = CW'(bc1(k));
      return v;
   endfunction

   function automatic logic [T2*CW-1:0] pk2();
      logic [T2*CW-1:0] v;
      for (int k = 0; k < T2; k++) v[k*CW +: CW] = CW'(bc2(k));
      return v;
   endfunction

   logic                   clk = 1'b0;
   logic                   rst = 1'b1;
   logic                   in_valid = 1'b0;
   logic signed [IN_W-1:0] in_sample = '0;
   logic                   det_valid;
   logic                   det_pulse;

   always #5 clk = ~clk;

   pulse_env_detector #(
      .IN_W(IN_W), .IN_FRAC(FRAC), .GAIN_SH(2), .COEF_W(CW), .COEF_FRAC(15),
      .TAPS1(T1), .DECIM(D), .TAPS2(T2), .SYMMETRIC(1'b1),
      .COEF1(pk1()), .COEF2(pk2())
   ) u_pulse_env_detector (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .det_valid(det_valid), .det_pulse(det_pulse));

   typedef struct {
      bit     exp;
      longint cap;
      string  tag;
      bit     quiet;
   } item_t;

   item_t  sb[$];
   int     errs = 0, checks = 0;
   longint cyc = 0;
   int     n_out = 0, n_push = 0, hits = 0, quiet_hits = 0;
   bit     last_pulse = 1'b0;
   bit     done = 1'b0;
   int unsigned rs = 32'h1234_5678;

   longint h1 [T1];
   longint h2 [T2];
   int     dcnt = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int noise();
      rs = rs ^ (rs << 13);
      rs = rs ^ (rs >> 17);
      rs = rs ^ (rs << 5);
      return int'(rs % 257) - 128;
   endfunction

   function automatic bit coin(int pct);
      rs = rs ^ (rs << 13);
      rs = rs ^ (rs >> 17);
      rs = rs ^ (rs << 5);
      return (rs % 100) < pct;
   endfunction

   task automatic model_clear();
      for (int k = 0; k < T1; k++) h1[k] = 0;
      for (int k = 0; k < T2; k++) h2[k] = 0;
      dcnt = 0;
   endtask

   // Drive one cycle; a valid sample also advances the reference model.
   task automatic step(input int x, input bit v, input string tag, input bit quiet);
      longint acc, y1, y2;
      item_t  it;
      @(negedge clk);
      in_valid  = v;
      in_sample = IN_W'(x);
      if (v) begin
         for (int k = T1 - 1; k > 0; k--) h1[k] = h1[k-1];
         h1[0] = 4 * longint'(x) * longint'(x);
         acc = 0;
         for (int k = 0; k < T1; k++) acc += bc1(k) * h1[k];
         y1 = acc >>> 15;
         dcnt++;
         if (dcnt == D) begin
            dcnt = 0;
            for (int k = T2 - 1; k > 0; k--) h2[k] = h2[k-1];
            h2[0] = y1;
            acc = 0;
            for (int k = 0; k < T2; k++) acc += bc2(k) * h2[k];
            y2 = acc >>> 15;
            it.exp = (y2 > THR);
            it.cap = cyc + 1;
            it.tag = tag;
            it.quiet = quiet;
            sb.push_back(it);
            n_push++;
         end
      end
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(2047, 1'b0, tag, 1'b0);
   endtask

   // Monitor: pops each decision and compares value and latency (R6).
   always @(negedge clk) begin
      if (!rst && det_valid) begin
         n_out++;
         last_pulse = det_pulse;
         if (det_pulse) hits++;
         if (sb.size() == 0) begin
            chk(1'b0, "R7", "unexpected decision", 1, 0);
         end else begin
            item_t it;
            it = sb.pop_front();
            if (it.quiet && det_pulse) quiet_hits++;
            chk(det_pulse == it.exp, it.tag, "decision bit", det_pulse, it.exp);
            chk(cyc - it.cap == 4, "R6", "latency", cyc - it.cap, 4);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "R6", "watchdog expired", 0, 1);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      real ph, w;
      int  hb, out_mark;
      model_clear();
      repeat (3) @(negedge clk);
      chk(det_valid == 1'b0 && det_pulse == 1'b0, "R8", "outputs in reset", det_valid, 0);
      rst = 1'b0;

      // Noise only, gapped input: no detection expected (R10).
      for (int i = 0; i < 300; i++) step(noise(), coin(80), "R10", 1'b1);

      // Chirped pulse in noise, sign symmetry of squaring (R1).
      hb = hits;
      ph = 0.0; w = 0.3;
      for (int i = 0; i < 600; i++) begin
         step(int'(700.0 * $sin(ph)) + noise(), 1'b1, "R1", 1'b0);
         ph = ph + w; w = w + 0.0005;
      end
      idle(8, "R1");
      chk(hits > hb, "R5", "pulse detected", hits - hb, 1);

      // Noise after pulse: tails flush, then silence (R10).
      for (int i = 0; i < 600; i++) step(noise(), coin(75), "R10", i >= 150);

      // Long idle with garbage on the data pins (R7).
      idle(10, "R7");
      out_mark = n_out;
      idle(60, "R7");
      chk(n_out == out_mark, "R7", "outputs while idle", n_out - out_mark, 0);

      // Second pulse at another frequency, gapped (R4).
      ph = 0.0;
      for (int i = 0; i < 500; i++) begin
         step(int'(650.0 * $sin(ph)) + noise(), coin(70), "R4", 1'b0);
         ph = ph + 1.2;
      end
      for (int i = 0; i < 400; i++) step(noise(), 1'b1, "R10", i >= 150);

      // Short burst then zeros: tap count shapes the decision run (R4).
      for (int i = 0; i < 4; i++) step(2047, 1'b1, "R4", 1'b0);
      for (int i = 0; i < 200; i++) step(0, 1'b1, "R4", 1'b0);

      // Full-scale negative, sustained (R9).
      for (int i = 0; i < 200; i++) step(-2048, 1'b1, "R9", 1'b0);
      idle(8, "R9");
      chk(last_pulse == 1'b1, "R9", "full-scale detection", last_pulse, 1);

      // Threshold boundary: 4*404^2 below 2.5, 4*405^2 above (R2, R5).
      for (int i = 0; i < 200; i++) step(404, 1'b1, "R5", 1'b0);
      idle(8, "R5");
      chk(last_pulse == 1'b0, "R5", "just below threshold", last_pulse, 0);
      for (int i = 0; i < 200; i++) step(-405, 1'b1, "R2", 1'b0);
      idle(8, "R2");
      chk(last_pulse == 1'b1, "R2", "just above threshold", last_pulse, 1);

      // Reset in the middle of activity (R8).
      for (int i = 0; i < 100; i++) step(int'(700.0 * $sin(0.5 * i)), 1'b1, "R8", 1'b0);
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk(det_valid == 1'b0, "R8", "strobe during reset", det_valid, 0);
      n_push -= sb.size();
      sb.delete();
      model_clear();
      rst = 1'b0;
      for (int i = 0; i < 150; i++) step(405, coin(90), "R8", 1'b0);
      idle(8, "R8");
      chk(last_pulse == 1'b1, "R8", "decision after reset", last_pulse, 1);

      idle(10, "R3");
      chk(sb.size() == 0, "R3", "pending decisions", sb.size(), 0);
      chk(n_out == n_push, "R3", "decision count", n_out, n_push);
      chk(quiet_hits == 0, "R10", "detections in noise", quiet_hits, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule